// File: doc/BRIEF.md
# DQS eye-centering delay sweep engine

This block is a training engine that locates the middle of the passing data window of a delay tap. It can steer either the read strobe delay or the write data delay. After a start pulse it steps the tap from zero to its largest value. For each tap it writes one cache line of a fixed test pattern through a generic memory request port, reads the same line back and compares every returned word with the pattern. The result of each trial is fed to a run tracker. The tracker remembers the widest stretch of consecutive passing taps.

At the end of the sweep the engine checks the widest run. If that run holds at least a minimum number of taps, the engine drives the tap to the run's midpoint, rounded down, and raises done. If no run is long enough, it raises done and error and drives the default tap. The delay line itself and all DRAM command timing sit outside this block. The memory side sees plain write and read requests with a ready handshake and read data that comes back in order.

Top module: `eye_center_sweep`

## Requirements
- R1: After synchronous reset the tap output equals DEFAULT_TAP, done and error are 0 and no request is valid.
- R2: Each trial issues WORDS write requests to the consecutive word addresses BASE_ADDR, BASE_ADDR+1, and so on. These are followed by WORDS read requests to the same addresses in the same order. Every write word carries 0x55 in its even-numbered bytes (bits 7:0, 23:16, ...) and 0xAA in its odd-numbered bytes, which gives 0xAA55AA55AA55AA55 for a 64-bit word. A request that is valid but not accepted holds its address, data and direction.
- R3: The tap output takes the values 0, 1, ... up to 2^TAP_W-1, one value per trial in increasing order. It stays constant while the trial's requests are outstanding.
- R4: A tap passes only if all WORDS read responses equal the pattern word. A single differing word in any position fails the tap.
- R5: The widest run of consecutive passing taps is selected. When two runs are equally wide, the run with the lower taps is kept.
- R6: A run that still passes at the largest tap is closed at the end of the sweep and takes part in the selection.
- R7: If the selected run holds at least MIN_RUN taps, the final tap is (first + last) >> 1 of that run, done is 1 and error is 0. The result holds until the next start.
- R8: If no run reaches MIN_RUN taps, including the case of no passing tap at all, done and error are both 1 and the tap returns to DEFAULT_TAP.
- R9: A start pulse during a sweep is ignored, so the sweep and its result are unchanged. A start when idle clears done and error and begins a new sweep.
- R10: No request is issued while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a sweep (ignored while busy) |
| mem_req_valid | output | 1 | Request valid |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rsp_valid | input | 1 | Read data valid, responses return in request order |
| mem_rsp_data | input | DATA_W | Read data |
| delay_tap | output | TAP_W | Tap value driven to the delay line |
| train_done | output | 1 | Sweep finished, result on delay_tap |
| train_error | output | 1 | No window of at least MIN_RUN taps was found |

## Verification
The bench builds the engine with a 4-bit tap (16 taps), eight 64-bit words, MIN_RUN of 3 and DEFAULT_TAP of 5. At that size a full sweep is short, so runs that touch tap 0 or the last tap, two runs of equal width, runs of exactly the minimum length and runs that are too short can all be set up from a per-tap pass mask. The bench corrupts a different word position depending on the tap, so every word of the comparison is exercised. A memory model stalls ready on a fixed cadence and returns read data two cycles late. This tests that requests stay stable under back-pressure and that the response count does not depend on arrival timing.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_TRIAL  = 2'd1,
    SW_FINISH = 2'd2
  } sweep_state_e;

  localparam logic [7:0] PAT_EVEN_BYTE = 8'h55;
  localparam logic [7:0] PAT_ODD_BYTE  = 8'hAA;
endpackage

// File: rtl/ecs_run_tracker.sv
module ecs_run_tracker #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             mark,
  input  logic             pass,
  input  logic             last,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] best_first,
  output logic [TAP_W-1:0] best_last,
  output logic [TAP_W:0]   best_len
);
  logic             in_run;
  logic [TAP_W-1:0] run_first;
  logic [TAP_W-1:0] cls_first;
  logic [TAP_W-1:0] cls_last;
  logic [TAP_W:0]   cls_len;
  logic             cls_now;

  always_comb begin
    cls_now   = mark && ((pass && last) || (!pass && in_run));
    cls_first = (pass && !in_run) ? tap : run_first;
    cls_last  = pass ? tap : (tap - TAP_W'(1));
    cls_len   = {1'b0, cls_last} - {1'b0, cls_first} + (TAP_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_run     <= 1'b0;
      run_first  <= '0;
      best_first <= '0;
      best_last  <= '0;
      best_len   <= '0;
    end else if (mark) begin
      if (pass && !in_run) begin
        in_run    <= 1'b1;
        run_first <= tap;
      end
      if (!pass) in_run <= 1'b0;
      if (cls_now && (cls_len > best_len)) begin
        best_first <= cls_first;
        best_last  <= cls_last;
        best_len   <= cls_len;
      end
    end
  end
endmodule

// File: rtl/ecs_line_trial.sv
module ecs_line_trial
  import ecs_pkg::*;
#(
  parameter int              WORDS     = 8,
  parameter int              DATA_W    = 64,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              fin,
  output logic              pass
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] pat;
  logic [CNT_W-1:0]  issued;
  logic [CNT_W-1:0]  got;
  logic              active;
  logic              rd_phase;
  logic              bad;

  for (genvar b = 0; b < BYTES; b++) begin : g_pat
    assign pat[8*b +: 8] = (b % 2 == 0) ? PAT_EVEN_BYTE : PAT_ODD_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      issued    <= '0;
      got       <= '0;
      active    <= 1'b0;
      rd_phase  <= 1'b0;
      bad       <= 1'b0;
      fin       <= 1'b0;
      pass      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        active    <= 1'b1;
        rd_phase  <= 1'b0;
        issued    <= '0;
        got       <= '0;
        bad       <= 1'b0;
        req_valid <= 1'b1;
        req_write <= 1'b1;
        req_addr  <= BASE_ADDR;
        req_wdata <= pat;
      end else if (active) begin
        if (req_valid && req_ready) begin
          if (issued == CNT_W'(WORDS - 1)) begin
            issued <= '0;
            if (!rd_phase) begin
              rd_phase  <= 1'b1;
              req_write <= 1'b0;
              req_addr  <= BASE_ADDR;
            end else begin
              req_valid <= 1'b0;
            end
          end else begin
            issued   <= issued + CNT_W'(1);
            req_addr <= req_addr + ADDR_W'(1);
          end
        end
        if (rsp_valid && rd_phase) begin
          got <= got + CNT_W'(1);
          if (rsp_data != pat) bad <= 1'b1;
        end
        if (got == CNT_W'(WORDS)) begin
          active <= 1'b0;
          fin    <= 1'b1;
          pass   <= !bad;
        end
      end
    end
  end
endmodule

// File: rtl/eye_center_sweep.sv
module eye_center_sweep
  import ecs_pkg::*;
#(
  parameter int                TAP_W       = 5,
  parameter int                WORDS       = 8,
  parameter int                DATA_W      = 64,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
  parameter int                MIN_RUN     = 3,
  parameter logic [TAP_W-1:0]  DEFAULT_TAP = TAP_W'(1 << (TAP_W - 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [TAP_W-1:0]  delay_tap,
  output logic              train_done,
  output logic              train_error
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W:0]   RUN_MIN = (TAP_W+1)'(MIN_RUN);

  sweep_state_e     state;
  logic             trial_go;
  logic             trk_clr;
  logic             trial_fin;
  logic             trial_pass;
  logic [TAP_W-1:0] best_first;
  logic [TAP_W-1:0] best_last;
  logic [TAP_W:0]   best_len;
  logic [TAP_W:0]   mid_sum;

  assign mid_sum = {1'b0, best_first} + {1'b0, best_last};

  ecs_line_trial #(
    .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_trial (
    .clk(clk), .rst(rst), .go(trial_go),
    .req_valid(mem_req_valid), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .fin(trial_fin), .pass(trial_pass)
  );

  ecs_run_tracker #(.TAP_W(TAP_W)) u_track (
    .clk(clk), .rst(rst), .clr(trk_clr),
    .mark(trial_fin), .pass(trial_pass),
    .last(delay_tap == TAP_MAX), .tap(delay_tap),
    .best_first(best_first), .best_last(best_last), .best_len(best_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SW_IDLE;
      delay_tap   <= DEFAULT_TAP;
      train_done  <= 1'b0;
      train_error <= 1'b0;
      trial_go    <= 1'b0;
      trk_clr     <= 1'b0;
    end else begin
      trial_go <= 1'b0;
      trk_clr  <= 1'b0;
      unique case (state)
        SW_IDLE: begin
          if (start) begin
            state       <= SW_TRIAL;
            delay_tap   <= '0;
            train_done  <= 1'b0;
            train_error <= 1'b0;
            trial_go    <= 1'b1;
            trk_clr     <= 1'b1;
          end
        end
        SW_TRIAL: begin
          if (trial_fin) begin
            if (delay_tap == TAP_MAX) begin
              state <= SW_FINISH;
            end else begin
              delay_tap <= delay_tap + TAP_W'(1);
              trial_go  <= 1'b1;
            end
          end
        end
        SW_FINISH: begin
          state      <= SW_IDLE;
          train_done <= 1'b1;
          if (best_len >= RUN_MIN) begin
            delay_tap <= mid_sum[TAP_W:1];
          end else begin
            delay_tap   <= DEFAULT_TAP;
            train_error <= 1'b1;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
  parameter int TAP_W  = 5,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ready,
  input logic [TAP_W-1:0]  tap,
  input logic              done,
  input logic              error
);
  // R2: a stalled request keeps its contents
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)));

  // R3: the tap does not move while requests are outstanding
  p_tap_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid)) |-> $stable(tap));

  // R10: nothing is requested once the sweep has finished
  p_quiet_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  // R8: error is only reported together with done
  p_error_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  // R7: the result holds until a new start
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(tap) && $stable(error)));
endmodule

bind eye_center_sweep ecs_checker #(
  .TAP_W(TAP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .req_valid(mem_req_valid), .req_write(mem_req_write),
  .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
  .req_ready(mem_req_ready),
  .tap(delay_tap), .done(train_done), .error(train_error)
);

// File: tb/tb_eye_center_sweep.sv
module tb_eye_center_sweep;
  localparam int              TAP_W  = 4;
  localparam int              WORDS  = 8;
  localparam int              DATA_W = 64;
  localparam int              ADDR_W = 16;
  localparam logic [15:0]     BASE   = 16'h0100;
  localparam int              MINRUN = 3;
  localparam logic [3:0]      DEFTAP = 4'd5;
  localparam int              NTAPS  = 1 << TAP_W;
  localparam logic [63:0]     PAT    = 64'hAA55AA55AA55AA55;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_req_ready = 1'b0;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [TAP_W-1:0]  delay_tap;
  logic              train_done, train_error;

  always #4 clk = ~clk;

  eye_center_sweep #(
    .TAP_W(TAP_W), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE), .MIN_RUN(MINRUN), .DEFAULT_TAP(DEFTAP)
  ) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int trial = 0;
  int idx = 0;
  int hs_count = 0;
  bit sweeping = 1'b0;
  logic [NTAPS-1:0] pass_mask = '0;
  logic [63:0] mem [0:WORDS-1];
  logic [63:0] rq_data[$];
  int          rq_due[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory and cycle-by-cycle request model
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      mem_req_ready = (cyc % 5) != 2;
      if (!sweeping) chk(!mem_req_valid, "R10 no request while idle", mem_req_valid, 0);
      if (mem_req_valid && mem_req_ready) begin
        int w;
        hs_count++;
        w = idx % WORDS;
        chk(delay_tap == trial[TAP_W-1:0], "R3 tap order", delay_tap, trial);
        chk(mem_req_write == (idx < WORDS), "R2 direction", mem_req_write, idx < WORDS);
        chk(mem_req_addr == BASE + 16'(w), "R2 address", mem_req_addr, BASE + 16'(w));
        if (mem_req_write) begin
          chk(mem_req_wdata == PAT, "R2 pattern", mem_req_wdata, PAT);
          mem[w] = mem_req_wdata;
        end else begin
          logic [63:0] d;
          d = mem[w];
          if (!pass_mask[trial] && (w == trial % WORDS)) d = d ^ 64'h100;
          rq_data.push_back(d);
          rq_due.push_back(cyc + 2);
        end
        idx++;
        if (idx == 2 * WORDS) begin
          idx = 0;
          trial++;
        end
      end
      if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
        void'(rq_due.pop_front());
        mem_rsp_data  = rq_data.pop_front();
        mem_rsp_valid = 1'b1;
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  function automatic void ref_result(input logic [NTAPS-1:0] m, output int tap, output bit err);
    int bf, bl, blen, rf;
    bit in;
    bf = 0; bl = 0; blen = 0; rf = 0; in = 0;
    for (int i = 0; i < NTAPS; i++) begin
      if (m[i] && !in) begin in = 1; rf = i; end
      if (in && (!m[i] || i == NTAPS - 1)) begin
        int e;
        e = m[i] ? i : i - 1;
        if (e - rf + 1 > blen) begin blen = e - rf + 1; bf = rf; bl = e; end
        if (!m[i]) in = 0;
      end
    end
    err = blen < MINRUN;
    tap = err ? int'(DEFTAP) : (bf + bl) / 2;
  endfunction

  task automatic run_sweep(input logic [NTAPS-1:0] m, input string tag, input bit poke);
    int exp_tap, w;
    bit exp_err;
    ref_result(m, exp_tap, exp_err);
    @(negedge clk);
    pass_mask = m; trial = 0; idx = 0; hs_count = 0; sweeping = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!train_done && !train_error, {tag, " R9 start clears done/error"}, {train_done, train_error}, 0);
    w = 0;
    while (!train_done && w < 6000) begin
      @(negedge clk);
      w++;
      if (poke && w == 120) start = 1'b1;
      if (poke && w == 121) start = 1'b0;
    end
    sweeping = 1'b0;
    chk(train_done, {tag, " R7 sweep completes"}, train_done, 1);
    chk(hs_count == NTAPS * 2 * WORDS, {tag, " R3 one trial per tap"}, hs_count, NTAPS * 2 * WORDS);
    chk(delay_tap == exp_tap[TAP_W-1:0], {tag, " R7 final tap"}, delay_tap, exp_tap);
    chk(train_error == exp_err, {tag, " R8 error flag"}, train_error, exp_err);
    repeat (6) @(negedge clk);
    chk(train_done && delay_tap == exp_tap[TAP_W-1:0], {tag, " R7 result holds"}, delay_tap, exp_tap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(delay_tap == DEFTAP, "R1 reset tap", delay_tap, DEFTAP);
    chk(!train_done && !train_error && !mem_req_valid, "R1 reset flags",
        {train_done, train_error, mem_req_valid}, 0);
    run_sweep(16'h0FF0, "R4 centre window",     1'b0);
    run_sweep(16'h3F0E, "R5 widest of two / R9 busy start", 1'b1);
    run_sweep(16'h3C0F, "R5 tie keeps lower",   1'b0);
    run_sweep(16'hF000, "R6 run at top tap",    1'b0);
    run_sweep(16'h018C, "R8 short runs",        1'b0);
    run_sweep(16'h0000, "R8 no pass",           1'b0);
    run_sweep(16'h00E0, "R7 minimum run",       1'b0);
    run_sweep(16'hFFFF, "R4 all pass",          1'b0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule